// File: doc/BRIEF.md
# Bus Fault Retry and Halt Sequencer

This block supervises a single bus cycle of a processor core and decides what happens when an external watchdog reports a bus error. A bus error does nothing by itself. The sequencer reads the halt line to choose an action. If halt is inactive, the faulty cycle is dropped and the core is asked to start bus-error exception processing. If halt is active, the cycle's address, data and control are kept, the bus drivers are released, and the block waits. When halt is released, the same cycle is replayed. Only a limited number of such replays is allowed. A fault on a replayed cycle always becomes an exception.

Halt without a bus error lets the running cycle finish and then holds the core. The block also decides when the core itself is reset. This needs the reset and halt lines to be held low together for a set number of clocks. The three external lines (bus error, halt, reset) are active-low and asynchronous. Each one passes through a two-flop synchroniser before the logic uses it.

Top module: `bus_fault_seq`

## Requirements
- R1: A bus error seen during a cycle while halt is high ends the cycle. `bus_oe` drops and `exc_req` pulses high for exactly one clock.
- R2: A bus error seen during a cycle while halt is low ends the cycle without `exc_req`. `bus_oe` stays low and `hold_core` stays high for as long as halt stays low.
- R3: When halt is released after a held fault, `retry_req` pulses for one clock. In that same clock `bus_oe` is high again and `retry_addr`, `retry_data` and `retry_ctrl` equal the values captured when the cycle started, even if the cycle inputs have changed since.
- R4: Halt low without a bus error leaves the running cycle driving the bus until `cyc_done`. After that `hold_core` is high, `cyc_start` is ignored, and releasing halt clears `hold_core` and lets a new cycle start.
- R5: With the default limit of one replay, a bus error on a replayed cycle raises `exc_req` even when halt is low.
- R6: `core_reset` goes high once `reset_n` and `halt_n` have both been seen low for 10 consecutive synchronised clocks. It clears, and the count restarts from zero, as soon as either line goes high.
- R7: Each of `berr_n`, `halt_n` and `reset_n` takes effect on the third rising edge after it changes: two synchroniser flops, then the control logic.
- R8: A bus error while no cycle is running produces neither `exc_req` nor bus drive.
- R9: After `arst_n` reset, `bus_oe`, `hold_core`, `retry_req`, `exc_req` and `core_reset` are all low.
- R10: `cyc_start` while idle makes `bus_oe` high after the next edge. `cyc_done` makes it low after the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous block reset, active low |
| cyc_start | input | 1 | Start a bus cycle; fields are captured on acceptance |
| cyc_addr | input | ADDR_W | Address of the cycle being started |
| cyc_data | input | DATA_W | Data of the cycle being started |
| cyc_ctrl | input | CTRL_W | Control and function code of the cycle |
| cyc_done | input | 1 | Normal termination of the running cycle |
| berr_n | input | 1 | Bus-error line from the watchdog, active low, asynchronous |
| halt_n | input | 1 | Halt line, active low, asynchronous |
| reset_n | input | 1 | Reset line, active low, asynchronous |
| bus_oe | output | 1 | Address/data drivers enabled |
| hold_core | output | 1 | Core must not start new cycles |
| retry_req | output | 1 | One-clock pulse: replay the saved cycle |
| retry_addr | output | ADDR_W | Saved address |
| retry_data | output | DATA_W | Saved data |
| retry_ctrl | output | CTRL_W | Saved control |
| exc_req | output | 1 | One-clock pulse: start bus-error exception processing |
| core_reset | output | 1 | Qualified reset-with-halt condition |

## Verification
A bus error and a halt that arrive in the same clock during a cycle compete. The bench drives `berr_n` and `halt_n` low on the same falling edge, so both reach the control logic on the same rising edge. It then checks that the fault path wins: the bus floats and no exception is raised. The second collision is a bus error on a replayed cycle with halt still low. Here the retry limit must override the halt level. The bench judges this by seeing `exc_req` rather than a second float. Both collisions are also repeated with random cycle fields, and the replayed values are compared with the values captured at the start of each cycle.

// File: rtl/bfs_pkg.sv
package bfs_pkg;
   typedef enum logic [1:0] {
      S_IDLE  = 2'd0,
      S_RUN   = 2'd1,
      S_FLOAT = 2'd2,
      S_STALL = 2'd3
   } bfs_state_e;
endpackage

// File: rtl/bfs_sync.sv
module bfs_sync #(
   parameter int               WIDTH   = 3,
   parameter int               STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '1
) (
   input  logic             clk,
   input  logic             arst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("bfs_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
      end else begin
         chain[0] <= d;
         for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/bfs_rst_qual.sv
module bfs_rst_qual #(
   parameter int COUNT = 10
) (
   input  logic clk,
   input  logic arst_n,
   input  logic rst_a,
   input  logic halt_a,
   output logic core_reset
);
   localparam int CW = $clog2(COUNT + 1);
   localparam logic [CW-1:0] LIM = CW'(COUNT);

   generate
      if (COUNT < 1) begin : g_bad_count
         $error("bfs_rst_qual: COUNT must be positive");
      end
   endgenerate

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n)                 cnt <= '0;
      else if (!(rst_a && halt_a)) cnt <= '0;
      else if (cnt != LIM)         cnt <= cnt + 1'b1;
   end

   assign core_reset = (cnt == LIM);

   assert_drop_clears_R6: assert property (@(posedge clk) disable iff (!arst_n)
      !(rst_a && halt_a) |=> !core_reset);
   assert_needs_both_R6: assert property (@(posedge clk) disable iff (!arst_n)
      $rose(core_reset) |-> $past(rst_a && halt_a));
endmodule

// File: rtl/bfs_fsm.sv
module bfs_fsm
   import bfs_pkg::*;
#(
   parameter int ADDR_W      = 23,
   parameter int DATA_W      = 16,
   parameter int CTRL_W      = 4,
   parameter int RETRY_LIMIT = 1
) (
   input  logic              clk,
   input  logic              arst_n,
   input  logic              cyc_start,
   input  logic              cyc_done,
   input  logic [ADDR_W-1:0] cyc_addr,
   input  logic [DATA_W-1:0] cyc_data,
   input  logic [CTRL_W-1:0] cyc_ctrl,
   input  logic              berr_a,
   input  logic              halt_a,
   output logic              bus_oe,
   output logic              hold_core,
   output logic              retry_req,
   output logic              exc_req,
   output logic [ADDR_W-1:0] sv_addr,
   output logic [DATA_W-1:0] sv_data,
   output logic [CTRL_W-1:0] sv_ctrl
);
   localparam int TW = (RETRY_LIMIT < 1) ? 1 : $clog2(RETRY_LIMIT + 1);
   localparam logic [TW-1:0] LIM = TW'(RETRY_LIMIT);

   generate
      if (RETRY_LIMIT < 0 || RETRY_LIMIT > 15) begin : g_bad_limit
         $error("bfs_fsm: RETRY_LIMIT out of range 0..15");
      end
   endgenerate

   bfs_state_e    st;
   logic [TW-1:0] tries;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         st        <= S_IDLE;
         tries     <= '0;
         retry_req <= 1'b0;
         exc_req   <= 1'b0;
         sv_addr   <= '0;
         sv_data   <= '0;
         sv_ctrl   <= '0;
      end else begin
         retry_req <= 1'b0;
         exc_req   <= 1'b0;
         case (st)
            S_IDLE: begin
               if (halt_a) begin
                  st <= S_STALL;
               end else if (cyc_start) begin
                  st      <= S_RUN;
                  tries   <= '0;
                  sv_addr <= cyc_addr;
                  sv_data <= cyc_data;
                  sv_ctrl <= cyc_ctrl;
               end
            end
            S_RUN: begin
               if (berr_a) begin
                  if (halt_a && tries != LIM) begin
                     st <= S_FLOAT;
                  end else begin
                     st      <= S_IDLE;
                     exc_req <= 1'b1;
                  end
               end else if (cyc_done) begin
                  st <= halt_a ? S_STALL : S_IDLE;
               end
            end
            S_FLOAT: begin
               if (!halt_a) begin
                  st        <= S_RUN;
                  retry_req <= 1'b1;
                  tries     <= tries + 1'b1;
               end
            end
            default: begin
               if (!halt_a) st <= S_IDLE;
            end
         endcase
      end
   end

   assign bus_oe    = (st == S_RUN);
   assign hold_core = (st == S_FLOAT) || (st == S_STALL);

   assert_fault_exc_R1: assert property (@(posedge clk) disable iff (!arst_n)
      (st == S_RUN && berr_a && !halt_a) |=> (exc_req && !bus_oe));
   assert_fault_float_R2: assert property (@(posedge clk) disable iff (!arst_n)
      (st == S_RUN && berr_a && halt_a && tries != LIM) |=> (!bus_oe && !exc_req && hold_core));
   assert_retry_limit_R5: assert property (@(posedge clk) disable iff (!arst_n)
      (st == S_RUN && berr_a && tries == LIM) |=> exc_req);
   assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!arst_n)
      (st == S_IDLE && !cyc_start) |=> (!exc_req && !bus_oe));
   assert_halt_finish_R4: assert property (@(posedge clk) disable iff (!arst_n)
      (st == S_RUN && halt_a && !berr_a && !cyc_done) |=> bus_oe);
endmodule

// File: rtl/bus_fault_seq.sv
module bus_fault_seq #(
   parameter int ADDR_W      = 23,
   parameter int DATA_W      = 16,
   parameter int CTRL_W      = 4,
   parameter int RETRY_LIMIT = 1,
   parameter int RST_CYCLES  = 10,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              arst_n,
   input  logic              cyc_start,
   input  logic [ADDR_W-1:0] cyc_addr,
   input  logic [DATA_W-1:0] cyc_data,
   input  logic [CTRL_W-1:0] cyc_ctrl,
   input  logic              cyc_done,
   input  logic              berr_n,
   input  logic              halt_n,
   input  logic              reset_n,
   output logic              bus_oe,
   output logic              hold_core,
   output logic              retry_req,
   output logic [ADDR_W-1:0] retry_addr,
   output logic [DATA_W-1:0] retry_data,
   output logic [CTRL_W-1:0] retry_ctrl,
   output logic              exc_req,
   output logic              core_reset
);
   localparam int NLINES = 3;

   generate
      if (ADDR_W < 1 || DATA_W < 1 || CTRL_W < 1) begin : g_bad_width
         $error("bus_fault_seq: field widths must be positive");
      end
   endgenerate

   logic [NLINES-1:0] lines_q;
   logic              berr_a, halt_a, rst_a;

   bfs_sync #(.WIDTH(NLINES), .STAGES(SYNC_STAGES), .RST_VAL({NLINES{1'b1}})) u_sync (
      .clk    (clk),
      .arst_n (arst_n),
      .d      ({reset_n, halt_n, berr_n}),
      .q      (lines_q)
   );

   assign berr_a = ~lines_q[0];
   assign halt_a = ~lines_q[1];
   assign rst_a  = ~lines_q[2];

   bfs_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_W(CTRL_W),
             .RETRY_LIMIT(RETRY_LIMIT)) u_fsm (
      .clk       (clk),
      .arst_n    (arst_n),
      .cyc_start (cyc_start),
      .cyc_done  (cyc_done),
      .cyc_addr  (cyc_addr),
      .cyc_data  (cyc_data),
      .cyc_ctrl  (cyc_ctrl),
      .berr_a    (berr_a),
      .halt_a    (halt_a),
      .bus_oe    (bus_oe),
      .hold_core (hold_core),
      .retry_req (retry_req),
      .exc_req   (exc_req),
      .sv_addr   (retry_addr),
      .sv_data   (retry_data),
      .sv_ctrl   (retry_ctrl)
   );

   bfs_rst_qual #(.COUNT(RST_CYCLES)) u_rstq (
      .clk        (clk),
      .arst_n     (arst_n),
      .rst_a      (rst_a),
      .halt_a     (halt_a),
      .core_reset (core_reset)
   );

   assert_pulse_excl_R3: assert property (@(posedge clk) disable iff (!arst_n)
      !(retry_req && exc_req));
   assert_replay_drives_R3: assert property (@(posedge clk) disable iff (!arst_n)
      retry_req |-> (bus_oe && !hold_core));
   assert_exc_released_R1: assert property (@(posedge clk) disable iff (!arst_n)
      exc_req |-> !bus_oe);
   assert_exc_one_clk_R1: assert property (@(posedge clk) disable iff (!arst_n)
      exc_req |=> !exc_req);
endmodule

// File: tb/test_bus_fault_seq.sv
module test_bus_fault_seq;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 23, DW = 16, CW = 4;

   logic          clk = 1'b0;
   logic          arst_n, cyc_start, cyc_done, berr_n, halt_n, reset_n;
   logic [AW-1:0] cyc_addr, retry_addr;
   logic [DW-1:0] cyc_data, retry_data;
   logic [CW-1:0] cyc_ctrl, retry_ctrl;
   logic          bus_oe, hold_core, retry_req, exc_req, core_reset;
   int            n_run = 0, n_fail = 0;
   bit            done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   bus_fault_seq i_bus_fault_seq (
      .clk(clk), .arst_n(arst_n), .cyc_start(cyc_start), .cyc_addr(cyc_addr),
      .cyc_data(cyc_data), .cyc_ctrl(cyc_ctrl), .cyc_done(cyc_done),
      .berr_n(berr_n), .halt_n(halt_n), .reset_n(reset_n), .bus_oe(bus_oe),
      .hold_core(hold_core), .retry_req(retry_req), .retry_addr(retry_addr),
      .retry_data(retry_data), .retry_ctrl(retry_ctrl), .exc_req(exc_req),
      .core_reset(core_reset));

   function automatic logic [AW+DW+CW-1:0] exp_replay(logic [AW-1:0] a, logic [DW-1:0] d,
                                                     logic [CW-1:0] c);
      return {a, d, c};
   endfunction

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic start_cycle(logic [AW-1:0] a, logic [DW-1:0] d, logic [CW-1:0] c);
      cyc_addr = a; cyc_data = d; cyc_ctrl = c; cyc_start = 1'b1;
      tick(1);
      cyc_start = 1'b0;
      chk("R10", "bus_oe after start", 64'(bus_oe), 64'd1);
   endtask

   task automatic end_cycle();
      cyc_done = 1'b1;
      tick(1);
      cyc_done = 1'b0;
      chk("R10", "bus_oe after done", 64'(bus_oe), 64'd0);
   endtask

   task automatic fault_retry(logic [AW-1:0] a, logic [DW-1:0] d, logic [CW-1:0] c);
      start_cycle(a, d, c);
      cyc_addr = ~a; cyc_data = ~d; cyc_ctrl = ~c;
      berr_n = 1'b0; halt_n = 1'b0;
      tick(3);
      chk("R2", "bus_oe on held fault", 64'(bus_oe), 64'd0);
      chk("R2", "exc_req on held fault", 64'(exc_req), 64'd0);
      chk("R2", "hold_core on held fault", 64'(hold_core), 64'd1);
      berr_n = 1'b1;
      tick(5);
      chk("R2", "bus_oe while halted", 64'(bus_oe), 64'd0);
      halt_n = 1'b1;
      tick(2);
      chk("R7", "retry_req before 3rd edge", 64'(retry_req), 64'd0);
      tick(1);
      chk("R3", "retry_req", 64'(retry_req), 64'd1);
      chk("R3", "bus_oe on replay", 64'(bus_oe), 64'd1);
      chk("R3", "replay fields", 64'({retry_addr, retry_data, retry_ctrl}),
          64'(exp_replay(a, d, c)));
      tick(1);
      chk("R3", "retry_req one clock", 64'(retry_req), 64'd0);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual running expected finished");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      arst_n = 1'b0; cyc_start = 1'b0; cyc_done = 1'b0;
      berr_n = 1'b1; halt_n = 1'b1; reset_n = 1'b1;
      cyc_addr = '0; cyc_data = '0; cyc_ctrl = '0;
      tick(3);
      arst_n = 1'b1;
      tick(2);
      // R9: reset state
      chk("R9", "bus_oe", 64'(bus_oe), 64'd0);
      chk("R9", "hold_core", 64'(hold_core), 64'd0);
      chk("R9", "pulses", 64'({retry_req, exc_req}), 64'd0);
      chk("R9", "core_reset", 64'(core_reset), 64'd0);

      // R8: bus error with no cycle
      berr_n = 1'b0;
      tick(3);
      chk("R8", "exc_req idle", 64'(exc_req), 64'd0);
      chk("R8", "bus_oe idle", 64'(bus_oe), 64'd0);
      tick(2);
      chk("R8", "exc_req idle later", 64'(exc_req), 64'd0);
      berr_n = 1'b1;
      tick(4);

      // R10: plain cycle
      start_cycle(23'h12345, 16'hbeef, 4'h5);
      tick(2);
      chk("R10", "bus_oe mid cycle", 64'(bus_oe), 64'd1);
      end_cycle();

      // R1 / R7: fault with halt inactive
      start_cycle(23'h00abc, 16'h1111, 4'h2);
      berr_n = 1'b0;
      tick(2);
      chk("R7", "bus_oe before 3rd edge", 64'(bus_oe), 64'd1);
      tick(1);
      chk("R1", "exc_req", 64'(exc_req), 64'd1);
      chk("R1", "bus_oe dropped", 64'(bus_oe), 64'd0);
      tick(1);
      chk("R1", "exc_req one clock", 64'(exc_req), 64'd0);
      berr_n = 1'b1;
      tick(4);

      // R2 / R3 / R5: held fault, replay, second fault with halt still low
      fault_retry(23'h7fffff, 16'hffff, 4'hf);
      berr_n = 1'b0; halt_n = 1'b0;
      tick(3);
      chk("R5", "exc_req on replay fault", 64'(exc_req), 64'd1);
      chk("R5", "bus_oe on replay fault", 64'(bus_oe), 64'd0);
      chk("R5", "no second retry", 64'(retry_req), 64'd0);
      berr_n = 1'b1; halt_n = 1'b1;
      tick(4);
      chk("R5", "hold_core released", 64'(hold_core), 64'd0);

      // R4: halt alone
      start_cycle(23'h000001, 16'h0001, 4'h1);
      halt_n = 1'b0;
      tick(4);
      chk("R4", "cycle still drives", 64'(bus_oe), 64'd1);
      chk("R4", "no hold mid cycle", 64'(hold_core), 64'd0);
      cyc_done = 1'b1;
      tick(1);
      cyc_done = 1'b0;
      chk("R4", "bus_oe after done", 64'(bus_oe), 64'd0);
      chk("R4", "hold_core after done", 64'(hold_core), 64'd1);
      cyc_start = 1'b1;
      tick(1);
      cyc_start = 1'b0;
      chk("R4", "start ignored", 64'(bus_oe), 64'd0);
      halt_n = 1'b1;
      tick(3);
      chk("R4", "hold released", 64'(hold_core), 64'd0);
      start_cycle(23'h000002, 16'h0002, 4'h2);
      end_cycle();

      // R6: reset qualification
      reset_n = 1'b0; halt_n = 1'b0;
      tick(11);
      chk("R6", "core_reset before 10", 64'(core_reset), 64'd0);
      tick(1);
      chk("R6", "core_reset at 10", 64'(core_reset), 64'd1);
      tick(5);
      chk("R6", "core_reset held", 64'(core_reset), 64'd1);
      reset_n = 1'b1;
      tick(2);
      chk("R6", "core_reset sync latency", 64'(core_reset), 64'd1);
      tick(1);
      chk("R6", "core_reset cleared", 64'(core_reset), 64'd0);
      reset_n = 1'b0;
      tick(7);
      reset_n = 1'b1;
      tick(3);
      reset_n = 1'b0;
      tick(11);
      chk("R6", "count restarted", 64'(core_reset), 64'd0);
      tick(1);
      chk("R6", "core_reset after restart", 64'(core_reset), 64'd1);
      reset_n = 1'b1; halt_n = 1'b1;
      tick(4);

      // random held-fault replays
      for (int k = 0; k < 8; k++) begin
         logic [AW-1:0] ra;
         logic [DW-1:0] rd;
         logic [CW-1:0] rc;
         ra = AW'($urandom);
         rd = DW'($urandom);
         rc = CW'($urandom);
         fault_retry(ra, rd, rc);
         end_cycle();
         tick(int'($urandom_range(0, 3)));
      end

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule